// File: doc/BRIEF.md
# Frame-Committing Transmit Byte FIFO

This block is a circular byte buffer on the transmit side. It releases data to its reader only in whole frames. The producer pushes bytes at a write pointer. Those bytes stay hidden from the reader until a commit command copies the write pointer into a frame-start write pointer. A discard command drops a partly built frame by moving the write pointer back to that frame-start mark.

The consumer pops bytes at a read pointer. Storage is freed only when a frame-start read pointer moves forward. This lets software either rewind the reader to re-send a frame (retry) or free everything read so far (release). In auto-commit mode every successful pop frees its byte at once, and retry and release are ignored.

All four pointers are visible through a small register port. Software can read and overwrite any of them directly.

Top module: `txfrm_fifo`

## Requirements
- R1: After reset all four pointers read 0, both flags are 0, and `pop_data` is 0x00.
- R2: An accepted push stores `push_data` at the write-pointer offset and advances the write pointer by one, modulo 128 (127 wraps to 0).
- R3: A push is refused when the write pointer plus one (mod 128) equals the frame-start read pointer. A refused push changes no pointer or byte and raises `ovf_o` for one cycle in the following cycle, so at most 127 bytes are held.
- R4: While committed data is waiting, `pop_data` shows the byte at the read-pointer offset. A pop advances the read pointer by one, modulo 128.
- R5: When the read pointer equals the frame-start write pointer, `pop_data` is 0x00. A pop in that state changes no pointer and raises `udf_o` for one cycle in the following cycle.
- R6: A commit copies the write pointer into the frame-start write pointer.
- R7: On the write side, discard beats commit and commit beats push. A discard copies the frame-start write pointer into the write pointer. A push presented together with either command is dropped without a flag.
- R8: With auto-commit off, retry copies the frame-start read pointer into the read pointer, and release copies the read pointer into the frame-start read pointer. Retry beats release, and release beats pop. A dropped pop raises no flag.
- R9: With auto-commit on, a successful pop also advances the frame-start read pointer by one, and retry and release have no effect.
- R10: `reg_sel` picks a pointer: 0 write, 1 read, 2 frame-start write, 3 frame-start read. `reg_rdata` shows it combinationally. When `reg_we` is high, only the selected pointer is loaded with `reg_wdata`. Every push, pop and command in that cycle is dropped without a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_autocommit | input | 1 | Free each byte as it is popped |
| push_valid | input | 1 | Push one byte this cycle |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop one byte this cycle |
| pop_data | output | 8 | Byte at the read pointer, 0x00 when none is waiting |
| cmd_commit | input | 1 | Publish the frame being written |
| cmd_discard | input | 1 | Drop the frame being written |
| cmd_retry | input | 1 | Rewind the reader to the frame start |
| cmd_release | input | 1 | Free the bytes read so far |
| reg_we | input | 1 | Load the selected pointer |
| reg_sel | input | 2 | Pointer select |
| reg_wdata | input | 7 | Value to load |
| reg_rdata | output | 7 | Selected pointer value |
| ovf_o | output | 1 | Refused-push pulse |
| udf_o | output | 1 | Failed-pop pulse |

## Verification
On every cycle, assertions check these behaviours:
- A refused push or failed pop leaves its pointers unchanged and raises its flag.
- A successful pop steps the read pointer.
- In auto-commit mode, a pop also steps the frame-start read pointer.
- Commit and discard copy the right pointer.

Only the bench's scenarios can show the rest:
- That bytes come back with the values and in the order they were pushed.
- That the 127-byte capacity is reached exactly, with wrap-around.
- That the priority rules hold, and that retry re-delivers the same bytes.
- That register-port loads block all other updates.

// File: rtl/txfrm_fifo.sv
module txfrm_fifo #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_autocommit,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  input  logic          cmd_commit,
  input  logic          cmd_discard,
  input  logic          cmd_retry,
  input  logic          cmd_release,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          ovf_o,
  output logic          udf_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, swr_q, srd_q;

  wire has_data   = rd_q != swr_q;
  wire full       = (wr_q + ONE) == srd_q;
  wire push_try   = push_valid & ~reg_we & ~cmd_discard & ~cmd_commit;
  wire push_ok    = push_try & ~full;
  wire rd_cmd_en  = ~reg_we & ~cfg_autocommit;
  wire retry_do   = rd_cmd_en & cmd_retry;
  wire release_do = rd_cmd_en & cmd_release & ~cmd_retry;
  wire pop_try    = pop_req & ~reg_we & ~retry_do & ~release_do;
  wire pop_ok     = pop_try & has_data;

  assign pop_data = has_data ? mem[rd_q] : '0;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = wr_q;
      2'd1:    reg_rdata = rd_q;
      2'd2:    reg_rdata = swr_q;
      default: reg_rdata = srd_q;
    endcase
  end

  always_ff @(posedge clk)
    if (push_ok) mem[wr_q] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      swr_q <= '0;
      srd_q <= '0;
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      ovf_o <= push_try & full;
      udf_o <= pop_try & ~has_data;
      if (reg_we) begin
        case (reg_sel)
          2'd0:    wr_q  <= reg_wdata;
          2'd1:    rd_q  <= reg_wdata;
          2'd2:    swr_q <= reg_wdata;
          default: srd_q <= reg_wdata;
        endcase
      end else begin
        if (cmd_discard)     wr_q  <= swr_q;
        else if (cmd_commit) swr_q <= wr_q;
        else if (push_ok)    wr_q  <= wr_q + ONE;

        if (retry_do)         rd_q  <= srd_q;
        else if (release_do)  srd_q <= rd_q;
        else if (pop_ok) begin
          rd_q <= rd_q + ONE;
          if (cfg_autocommit) srd_q <= srd_q + ONE;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_try && full) |=> (ovf_o && $stable(wr_q))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_try && !has_data) |=> (udf_o && $stable(rd_q) && $stable(srd_q))); // R5
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> rd_q == AW'($past(rd_q) + ONE)); // R4
  AST_AUTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && cfg_autocommit) |=> srd_q == AW'($past(srd_q) + ONE)); // R9
  AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit && !cmd_discard && !reg_we) |=> swr_q == $past(wr_q)); // R6
  AST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_discard && !reg_we) |=> wr_q == $past(swr_q)); // R7
endmodule

// File: tb/sim_txfrm_fifo.sv
`timescale 1ns/100ps
module sim_txfrm_fifo;
  logic clk = 0, rst_n = 0, cfg_autocommit = 0;
  logic push_valid = 0, pop_req = 0;
  logic cmd_commit = 0, cmd_discard = 0, cmd_retry = 0, cmd_release = 0;
  logic reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [6:0] reg_wdata = 0, reg_rdata;
  logic [7:0] push_data = 0, pop_data;
  logic ovf_o, udf_o;

  int checks = 0, errors = 0;
  int m_wr = 0, m_rd = 0, m_swr = 0, m_srd = 0;
  logic [7:0] m_mem [128];

  always #2.5 clk = ~clk;

  txfrm_fifo u0 (.clk, .rst_n, .cfg_autocommit, .push_valid, .push_data,
    .pop_req, .pop_data, .cmd_commit, .cmd_discard, .cmd_retry, .cmd_release,
    .reg_we, .reg_sel, .reg_wdata, .reg_rdata, .ovf_o, .udf_o);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_ptrs(input string tag);
    int got [4];
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s);
      #0.1;
      got[s] = int'(reg_rdata);
    end
    chk({tag, " wr"}, got[0], m_wr);
    chk({tag, " rd"}, got[1], m_rd);
    chk({tag, " swr"}, got[2], m_swr);
    chk({tag, " srd"}, got[3], m_srd);
  endtask

  // One cycle of stimulus, model update per the requirements, then checks.
  task automatic cyc(input string tag, input bit pv, input logic [7:0] pd,
                     input bit pr, input bit cm, input bit ds, input bit rt,
                     input bit rl, input bit we = 0, input int sel = 0,
                     input int wd = 0);
    int o_wr = m_wr, o_rd = m_rd, o_swr = m_swr, o_srd = m_srd;
    bit e_ovf = 0, e_udf = 0;
    bit avail = (o_rd != o_swr);
    push_valid = pv; push_data = pd; pop_req = pr;
    cmd_commit = cm; cmd_discard = ds; cmd_retry = rt; cmd_release = rl;
    reg_we = we; reg_sel = 2'(sel); reg_wdata = 7'(wd);
    #0.1;
    chk({tag, " pop_data"}, int'(pop_data), avail ? int'(m_mem[o_rd]) : 0);
    if (we) begin
      case (sel)
        0: m_wr = wd;
        1: m_rd = wd;
        2: m_swr = wd;
        default: m_srd = wd;
      endcase
    end else begin
      if (ds) m_wr = o_swr;
      else if (cm) m_swr = o_wr;
      else if (pv) begin
        if ((o_wr + 1) % 128 == o_srd) e_ovf = 1;
        else begin m_mem[o_wr] = pd; m_wr = (o_wr + 1) % 128; end
      end
      if (!cfg_autocommit && rt) m_rd = o_srd;
      else if (!cfg_autocommit && rl) m_srd = o_rd;
      else if (pr) begin
        if (!avail) e_udf = 1;
        else begin
          m_rd = (o_rd + 1) % 128;
          if (cfg_autocommit) m_srd = (o_srd + 1) % 128;
        end
      end
    end
    @(negedge clk);
    push_valid = 0; pop_req = 0; cmd_commit = 0; cmd_discard = 0;
    cmd_retry = 0; cmd_release = 0; reg_we = 0;
    chk({tag, " ovf"}, int'(ovf_o), int'(e_ovf));
    chk({tag, " udf"}, int'(udf_o), int'(e_udf));
    check_ptrs(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 udf", int'(udf_o), 0);
    chk("R1 pop_data", int'(pop_data), 0);
    check_ptrs("R1");

    cyc("R5 empty pop", 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 127; i++)
      cyc("R2 fill", 1, 8'((i * 7 + 3) & 255), 0, 0, 0, 0, 0);
    cyc("R3 full push", 1, 8'hEE, 0, 0, 0, 0, 0);
    cyc("R5 uncommitted pop", 0, 0, 1, 0, 0, 0, 0);
    cyc("R6 commit", 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 127; i++)
      cyc("R4 drain", 0, 0, 1, 0, 0, 0, 0);
    cyc("R5 drained pop", 0, 0, 1, 0, 0, 0, 0);
    cyc("R8 retry", 0, 0, 0, 0, 0, 1, 0);
    cyc("R4 reread", 0, 0, 1, 0, 0, 0, 0);
    cyc("R8 retry beats pop", 0, 0, 1, 0, 0, 1, 0);
    cyc("R4 reread again", 0, 0, 1, 0, 0, 0, 0);
    cyc("R8 release", 0, 0, 0, 0, 0, 0, 1);
    cyc("R2 wrap push", 1, 8'hA5, 0, 0, 0, 0, 0);
    cyc("R3 full after wrap", 1, 8'h5A, 0, 0, 0, 0, 0);
    cyc("R7 discard", 0, 0, 0, 0, 1, 0, 0);
    cyc("R7 commit beats push", 1, 8'h11, 0, 1, 0, 0, 0);
    cyc("R2 push", 1, 8'h22, 0, 0, 0, 0, 0);
    cyc("R7 discard beats commit", 1, 8'h33, 0, 1, 1, 0, 0);
    cyc("R8 release beats pop", 0, 0, 1, 0, 0, 0, 1);
    cfg_autocommit = 1;
    for (int i = 0; i < 4; i++)
      cyc("R9 auto pop", 0, 0, 1, 0, 0, 0, 0);
    cyc("R9 retry ignored", 0, 0, 0, 0, 0, 1, 0);
    cyc("R9 release ignored", 0, 0, 1, 0, 0, 0, 1);
    cfg_autocommit = 0;
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 128; v += 37)
        cyc("R10 load", 0, 0, 0, 0, 0, 0, 0, 1, s, v);
    cyc("R10 load wr", 0, 0, 0, 0, 0, 0, 0, 1, 0, 10);
    cyc("R10 load rd", 0, 0, 0, 0, 0, 0, 0, 1, 1, 10);
    cyc("R10 load swr", 0, 0, 0, 0, 0, 0, 0, 1, 2, 10);
    cyc("R10 load srd", 0, 0, 0, 0, 0, 0, 0, 1, 3, 11);
    cyc("R10 blocks all", 1, 8'h77, 1, 1, 1, 1, 1, 1, 3, 20);
    cyc("R10 blocked pop stays", 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++)
      cyc("R2 push after load", 1, 8'(8'h80 + i), 0, 0, 0, 0, 0);
    cyc("R6 commit after load", 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++)
      cyc("R4 pop after load", 0, 0, 1, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule